// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block recognises interrupts for a small 8-bit processor and runs the fixed entry sequence that moves the machine into a handler. It watches two hardware request lines and one software request. The first is an active-low non-maskable line that acts only on its falling transitions. The second is an active-low maskable line that is sensed by level. The third is a break request raised by the decoder. A request is only accepted at an instruction boundary. Every entry then takes the same seven cycles: two internal cycles, three stack pushes (return address high byte, return address low byte, status), and two vector fetches (low byte, then high byte).

The non-maskable line first passes through a synchronizer. A falling edge on the synchronized value sets a pending latch, so a line that stays low yields only one request, and the line must go high and then low again to raise another. The vector is not fixed when an entry starts. It is chosen during the status-push cycle. If the pending latch is set at that point, a maskable or break entry is redirected to the non-maskable vector and the latch is cleared. Once an entry completes, the next instruction boundary belongs to the handler's first instruction, so hardware interrupts are held off until the boundary after it.

The state machine walks through the states `ST_IDLE`, `ST_INT1`, `ST_INT2`, `ST_PUSH_PCH`, `ST_PUSH_PCL`, `ST_PUSH_STS`, `ST_VEC_LO`, `ST_VEC_HI`. The transition from `ST_IDLE` to `ST_INT1` is taken when a request is accepted. From `ST_INT1` to `ST_VEC_HI` each step advances unconditionally by one state per cycle. `ST_VEC_HI` returns to `ST_IDLE`.

Top module: `irq_entry_seq`

## Requirements
- R1: A 1-to-0 transition of the synchronized `nmi_n` sets a pending non-maskable request. A line held low yields exactly one entry. A further entry needs the line to go high and then low again. Each such re-armed edge that occurs after the previous one has been serviced gives exactly one entry.
- R2: A low pulse on `nmi_n` that spans no rising clock edge is lost. A pulse that is low across at least two rising edges is caught.
- R3: Requests are accepted only in `ST_IDLE` with `insn_boundary` high. The priority is non-maskable, then maskable, then break. The maskable line (`irq_n` low) is ignored while `mask_i` is 1.
- R4: Every entry keeps `busy` high for exactly seven cycles. `push_en` is high in cycles 3 to 5 of the entry, with `push_sel` = 0 (return high byte), then 1 (return low byte), then 2 (status). In every other cycle `push_en`, `vec_rd`, `set_mask`, `handler_go` and `push_brk` are 0.
- R5: `push_brk` is 1 during the status push of a break entry and 0 for hardware entries. This holds even when the vector has been redirected.
- R6: `vec_rd` is high in cycles 6 and 7. `vec_addr` is 0xFFFA then 0xFFFB for the non-maskable vector, and 0xFFFE then 0xFFFF for maskable and break entries.
- R7: The vector is chosen in the status-push cycle. A pending non-maskable request at that cycle redirects the entry to 0xFFFA and is consumed by it. An edge latched after that cycle is kept and serviced by a later entry.
- R8: `set_mask` is high in the vector-low cycle of every entry.
- R9: `handler_go` is high in the vector-high cycle. The first instruction boundary after an entry never starts a hardware entry, so the earliest next entry starts from the second boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_n | input | 1 | Asynchronous non-maskable request, active low, edge sensed |
| irq_n | input | 1 | Maskable request, active low, level sensed |
| mask_i | input | 1 | Current interrupt-disable flag from the status register |
| brk_req | input | 1 | Decoder asks for a software break entry at this boundary |
| insn_boundary | input | 1 | Current cycle ends an instruction |
| busy | output | 1 | Entry sequence in progress |
| push_en | output | 1 | Stack push strobe |
| push_sel | output | 2 | Pushed item: 0 return high, 1 return low, 2 status |
| push_brk | output | 1 | Break bit value for the status push |
| vec_rd | output | 1 | Vector fetch strobe |
| vec_addr | output | AW | Vector fetch address |
| set_mask | output | 1 | Set the interrupt-disable flag |
| handler_go | output | 1 | Last entry cycle; the next cycle fetches the handler's first opcode |

## Verification
Two events can land in the same cycle here: the latching of a fresh non-maskable edge, and the vector decision of a maskable or break entry that is already running. The bench forces this overlap by dropping `nmi_n` at chosen cycles of a running entry. An edge dropped in the first internal cycle must steer the entry to 0xFFFA. An edge dropped in the return-high push must leave the entry on 0xFFFE and produce a later entry of its own. A glitch that falls between two clock edges must produce nothing. The bench checks the fetched vector, the break bit, and whether or not a follow-up entry appears.

// File: rtl/irqs_pkg.sv
package irqs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INT1,
        ST_INT2,
        ST_PUSH_PCH,
        ST_PUSH_PCL,
        ST_PUSH_STS,
        ST_VEC_LO,
        ST_VEC_HI
    } entry_state_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_IRQ,
        SRC_BRK
    } src_kind_t;

    localparam logic [1:0] SLOT_PCH = 2'd0;
    localparam logic [1:0] SLOT_PCL = 2'd1;
    localparam logic [1:0] SLOT_STS = 2'd2;

endpackage

// File: rtl/irqs_nmi_latch.sv
module irqs_nmi_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic clr,
    output logic pend
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;
    logic          fall;

    // Synchronizer chain; the oldest stage is the one observed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[LAST-1:0], nmi_n};
            prev_q <= sync_q[LAST];
        end
    end

    assign fall = prev_q & ~sync_q[LAST];

    // A fresh edge wins over a clear issued in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend <= 1'b0;
        else if (fall) pend <= 1'b1;
        else if (clr)  pend <= 1'b0;
    end

endmodule

// File: rtl/irqs_arbiter.sv
module irqs_arbiter
    import irqs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      idle,
    input  logic      boundary,
    input  logic      nmi_pend,
    input  logic      irq_n,
    input  logic      mask_i,
    input  logic      brk_req,
    input  logic      entry_done,
    output logic      start,
    output src_kind_t start_src
);
    logic hold_q;
    logic take;

    assign take = idle && boundary;

    always_comb begin
        start_src = SRC_NONE;
        if (take) begin
            if (!hold_q && nmi_pend)               start_src = SRC_NMI;
            else if (!hold_q && !irq_n && !mask_i) start_src = SRC_IRQ;
            else if (brk_req)                      start_src = SRC_BRK;
        end
    end

    assign start = (start_src != SRC_NONE);

    // Hold off hardware requests until the handler's first instruction ends.
    always_ff @(posedge clk) begin
        if (!rst_n)          hold_q <= 1'b0;
        else if (entry_done) hold_q <= 1'b1;
        else if (take)       hold_q <= 1'b0;
    end

endmodule

// File: rtl/irqs_fsm.sv
module irqs_fsm
    import irqs_pkg::*;
#(
    parameter int             AW      = 16,
    parameter logic [AW-1:0]  NMI_VEC = 16'hFFFA,
    parameter logic [AW-1:0]  IRQ_VEC = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  src_kind_t     start_src,
    input  logic          nmi_pend,
    output logic          nmi_clr,
    output logic          busy,
    output logic          push_en,
    output logic [1:0]    push_sel,
    output logic          push_brk,
    output logic          vec_rd,
    output logic [AW-1:0] vec_addr,
    output logic          set_mask,
    output logic          handler_go
);
    entry_state_t  state_q, state_d;
    src_kind_t     src_q;
    logic          nmi_sel_q;
    logic          decide;
    logic [AW-1:0] vec_base;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_INT1;
            ST_INT1:     state_d = ST_INT2;
            ST_INT2:     state_d = ST_PUSH_PCH;
            ST_PUSH_PCH: state_d = ST_PUSH_PCL;
            ST_PUSH_PCL: state_d = ST_PUSH_STS;
            ST_PUSH_STS: state_d = ST_VEC_LO;
            ST_VEC_LO:   state_d = ST_VEC_HI;
            ST_VEC_HI:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    assign decide  = (state_q == ST_PUSH_STS);
    assign nmi_clr = decide && nmi_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            src_q     <= SRC_NONE;
            nmi_sel_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) src_q <= start_src;
            if (decide) nmi_sel_q <= nmi_pend;
        end
    end

    assign vec_base = nmi_sel_q ? NMI_VEC : IRQ_VEC;

    always_comb begin
        busy       = 1'b1;
        push_en    = 1'b0;
        push_sel   = SLOT_PCH;
        push_brk   = 1'b0;
        vec_rd     = 1'b0;
        vec_addr   = vec_base;
        set_mask   = 1'b0;
        handler_go = 1'b0;
        unique case (state_q)
            ST_IDLE:     busy = 1'b0;
            ST_INT1:     ;
            ST_INT2:     ;
            ST_PUSH_PCH: begin
                push_en  = 1'b1;
                push_sel = SLOT_PCH;
            end
            ST_PUSH_PCL: begin
                push_en  = 1'b1;
                push_sel = SLOT_PCL;
            end
            ST_PUSH_STS: begin
                push_en  = 1'b1;
                push_sel = SLOT_STS;
                push_brk = (src_q == SRC_BRK);
            end
            ST_VEC_LO: begin
                vec_rd   = 1'b1;
                set_mask = 1'b1;
            end
            ST_VEC_HI: begin
                vec_rd     = 1'b1;
                vec_addr   = vec_base + AW'(1);
                handler_go = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irqs_pkg::*;
#(
    parameter int            SYNC_STAGES = 2,
    parameter int            AW          = 16,
    parameter logic [AW-1:0] NMI_VEC     = 16'hFFFA,
    parameter logic [AW-1:0] IRQ_VEC     = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_n,
    input  logic          irq_n,
    input  logic          mask_i,
    input  logic          brk_req,
    input  logic          insn_boundary,
    output logic          busy,
    output logic          push_en,
    output logic [1:0]    push_sel,
    output logic          push_brk,
    output logic          vec_rd,
    output logic [AW-1:0] vec_addr,
    output logic          set_mask,
    output logic          handler_go
);
    logic      nmi_pend;
    logic      nmi_clr;
    logic      start;
    src_kind_t start_src;

    irqs_nmi_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .nmi_n (nmi_n),
        .clr   (nmi_clr),
        .pend  (nmi_pend)
    );

    irqs_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (!busy),
        .boundary   (insn_boundary),
        .nmi_pend   (nmi_pend),
        .irq_n      (irq_n),
        .mask_i     (mask_i),
        .brk_req    (brk_req),
        .entry_done (handler_go),
        .start      (start),
        .start_src  (start_src)
    );

    irqs_fsm #(.AW(AW), .NMI_VEC(NMI_VEC), .IRQ_VEC(IRQ_VEC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_src  (start_src),
        .nmi_pend   (nmi_pend),
        .nmi_clr    (nmi_clr),
        .busy       (busy),
        .push_en    (push_en),
        .push_sel   (push_sel),
        .push_brk   (push_brk),
        .vec_rd     (vec_rd),
        .vec_addr   (vec_addr),
        .set_mask   (set_mask),
        .handler_go (handler_go)
    );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       push_en,
    input logic [1:0] push_sel,
    input logic       push_brk,
    input logic       vec_rd,
    input logic [2:0] vec_lo,
    input logic       set_mask,
    input logic       handler_go,
    input logic       insn_boundary,
    input logic       brk_req
);
    logic [1:0] bnd_cnt;
    logic       seen;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bnd_cnt <= 2'd0;
            seen    <= 1'b0;
        end else if (handler_go) begin
            bnd_cnt <= 2'd0;
            seen    <= 1'b1;
        end else if (insn_boundary && !busy && bnd_cnt != 2'd3) begin
            bnd_cnt <= bnd_cnt + 2'd1;
        end
    end

    AST_PCH_THIRD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ##2 (push_en && push_sel == 2'd0)); // R4
    AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (push_en && push_sel == 2'd0) |=> (push_en && push_sel == 2'd1)); // R4
    AST_ENDS_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
        handler_go |=> !busy); // R4
    AST_BRK_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        push_brk |-> (push_en && push_sel == 2'd2)); // R5
    AST_VEC_LOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_rd) |-> (vec_lo[0] == 1'b0)); // R6
    AST_VEC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_rd) |=> (vec_rd && vec_lo[2] == $past(vec_lo[2]))); // R7
    AST_MASK_AT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_rd) |-> set_mask); // R8
    AST_GO_AT_VEC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        handler_go |-> (vec_rd && vec_lo[0])); // R9
    AST_ONE_INSN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && seen && !$past(brk_req)) |-> (bnd_cnt >= 2'd2)); // R9

endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .push_en       (push_en),
    .push_sel      (push_sel),
    .push_brk      (push_brk),
    .vec_rd        (vec_rd),
    .vec_lo        (vec_addr[2:0]),
    .set_mask      (set_mask),
    .handler_go    (handler_go),
    .insn_boundary (insn_boundary),
    .brk_req       (brk_req)
);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0, nmi_n = 1'b1, irq_n = 1'b1, mask_i = 1'b1;
    logic        brk_req = 1'b0, bnd = 1'b0;
    logic        busy, push_en, push_brk, vec_rd, set_mask, handler_go;
    logic [1:0]  push_sel;
    logic [15:0] vec_addr;

    irq_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n), .mask_i(mask_i),
        .brk_req(brk_req), .insn_boundary(bnd), .busy(busy), .push_en(push_en),
        .push_sel(push_sel), .push_brk(push_brk), .vec_rd(vec_rd),
        .vec_addr(vec_addr), .set_mask(set_mask), .handler_go(handler_go)
    );

    int tests = 0, fails = 0;
    int cnt = 0, ilen = 2;
    bit brk_arm = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_nmi_vec(input logic [15:0] v);
        return v == 16'hFFFA;
    endfunction

    // Per-entry monitor, sampled on the falling edge.
    int          idx = 0, n_entries = 0, n_nmi = 0, bnd_since = 0;
    bit          seq_ok, cur_brk, last_brk, had_entry = 0, idle_bad = 0;
    logic [15:0] cur_vec, last_vec;

    always @(negedge clk) begin
        if (!rst_n) begin
            idx = 0; had_entry = 0; bnd_since = 0;
        end else if (busy) begin
            idx++;
            if (idx == 1) begin
                seq_ok = 1;
                if (had_entry)
                    chk(bnd_since >= 2, "R9", "boundaries before next entry", bnd_since, 2);
            end
            if (push_en != (idx >= 3 && idx <= 5)) seq_ok = 0;
            if (idx >= 3 && idx <= 5 && push_sel != 2'(idx - 3)) seq_ok = 0;
            if (vec_rd != (idx >= 6)) seq_ok = 0;
            if (set_mask != (idx == 6)) seq_ok = 0;
            if (handler_go != (idx == 7)) seq_ok = 0;
            if (idx != 5 && push_brk) seq_ok = 0;
            if (idx == 5) cur_brk = push_brk;
            if (idx == 6) cur_vec = vec_addr;
            if (idx == 7 && vec_addr != cur_vec + 16'd1) seq_ok = 0;
        end else begin
            if (idx > 0) begin
                chk(idx == 7, "R4", "entry length", idx, 7);
                chk(seq_ok, "R4", "entry cycle order", int'(seq_ok), 1);
                chk(cur_vec == 16'hFFFA || cur_vec == 16'hFFFE, "R6", "vector address",
                    int'(cur_vec), 16'hFFFE);
                if (is_nmi_vec(cur_vec)) n_nmi++;
                n_entries++;
                last_vec = cur_vec; last_brk = cur_brk;
                had_entry = 1; bnd_since = 0; idx = 0;
            end
            if (push_en || vec_rd || handler_go || set_mask || push_brk) idle_bad = 1;
            if (bnd) bnd_since++;
        end
    end

    // One cycle of a simple processor model: boundaries every ilen idle cycles.
    task automatic tick();
        @(posedge clk); #2;
        if (set_mask) mask_i = 1'b1;
        if (busy) begin
            cnt = 0; bnd = 1'b0;
        end else begin
            cnt++;
            if (cnt >= ilen) begin bnd = 1'b1; cnt = 0; end
            else bnd = 1'b0;
        end
        brk_req = bnd && brk_arm;
        if (brk_req) brk_arm = 0;
    endtask

    task automatic run(input int n);
        repeat (n) tick();
    endtask

    task automatic wait_entries(input int target);
        int k = 0;
        while (n_entries < target && k < 300) begin tick(); k++; end
    endtask

    task automatic wait_busy();
        int k = 0;
        while (!busy && k < 300) begin tick(); k++; end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        #800000;
        tests++; fails++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int base;
        int nn;
        void'($urandom(32'd1234));
        run(4);
        rst_n = 1'b1;
        run(2);
        chk(!busy && !push_en && !vec_rd && !handler_go && !set_mask, "R4", "reset outputs",
            int'({busy, push_en, vec_rd, handler_go, set_mask}), 0);

        // R3: masked level request is ignored
        irq_n = 1'b0; mask_i = 1'b1;
        run(20);
        chk(n_entries == 0, "R3", "masked request entries", n_entries, 0);

        // Plain maskable entry
        mask_i = 1'b0;
        wait_busy(); irq_n = 1'b1;
        wait_entries(1);
        chk(last_vec == 16'hFFFE, "R6", "maskable vector", int'(last_vec), 16'hFFFE);
        chk(last_brk == 0, "R5", "maskable break bit", int'(last_brk), 0);
        chk(mask_i == 1'b1, "R8", "mask set on entry", int'(mask_i), 1);

        // Break entry
        run(8); brk_arm = 1;
        wait_entries(2);
        chk(last_vec == 16'hFFFE, "R6", "break vector", int'(last_vec), 16'hFFFE);
        chk(last_brk == 1, "R5", "break bit in status", int'(last_brk), 1);

        // R1: held low gives one entry, re-arm gives another
        run(8); base = n_entries;
        nmi_n = 1'b0; run(80);
        chk(n_entries == base + 1, "R1", "entries for held-low line", n_entries - base, 1);
        chk(is_nmi_vec(last_vec), "R6", "non-maskable vector", int'(last_vec), 16'hFFFA);
        nmi_n = 1'b1; run(20);
        chk(n_entries == base + 1, "R1", "entries after release", n_entries - base, 1);
        nmi_n = 1'b0; run(40); nmi_n = 1'b1;
        chk(n_entries == base + 2, "R1", "entries after re-arm", n_entries - base, 2);
        run(8);

        // R3: priority, both pending at one boundary
        ilen = 8; cnt = 0; base = n_entries;
        nmi_n = 1'b0; irq_n = 1'b0; mask_i = 1'b0;
        wait_entries(base + 1);
        chk(is_nmi_vec(last_vec), "R3", "priority winner vector", int'(last_vec), 16'hFFFA);
        run(30);
        chk(n_entries == base + 1, "R3", "maskable held by flag", n_entries - base, 1);
        ilen = 2; mask_i = 1'b0;
        wait_busy(); irq_n = 1'b1;
        wait_entries(base + 2);
        chk(last_vec == 16'hFFFE, "R3", "maskable after flag clear", int'(last_vec), 16'hFFFE);
        nmi_n = 1'b1; run(10);

        // R7 / R2: edge early in a maskable entry redirects it
        base = n_entries; irq_n = 1'b0; mask_i = 1'b0;
        wait_busy(); nmi_n = 1'b0; irq_n = 1'b1;
        wait_entries(base + 1);
        chk(is_nmi_vec(last_vec), "R7", "redirected maskable entry", int'(last_vec), 16'hFFFA);
        chk(last_brk == 0, "R5", "redirected hardware break bit", int'(last_brk), 0);
        run(40);
        chk(n_entries == base + 1, "R2", "caught edge consumed once", n_entries - base, 1);
        nmi_n = 1'b1; run(10);

        // R7: edge early in a break entry redirects, break bit kept
        base = n_entries; brk_arm = 1;
        wait_busy(); nmi_n = 1'b0;
        wait_entries(base + 1);
        chk(is_nmi_vec(last_vec), "R7", "redirected break entry", int'(last_vec), 16'hFFFA);
        chk(last_brk == 1, "R5", "redirected break bit", int'(last_brk), 1);
        run(30); nmi_n = 1'b1; run(10);

        // R7: edge after the decision stays pending for a later entry
        base = n_entries; nn = n_nmi; irq_n = 1'b0; mask_i = 1'b0;
        wait_busy(); irq_n = 1'b1;
        tick(); tick(); nmi_n = 1'b0;
        wait_entries(base + 1);
        chk(last_vec == 16'hFFFE, "R7", "late edge keeps vector", int'(last_vec), 16'hFFFE);
        wait_entries(base + 2);
        chk(n_nmi == nn + 1 && is_nmi_vec(last_vec), "R7", "late edge serviced later",
            n_nmi - nn, 1);
        run(20); nmi_n = 1'b1; run(10);

        // R2: glitch between clock edges during a maskable entry is lost
        base = n_entries; irq_n = 1'b0; mask_i = 1'b0;
        wait_busy(); irq_n = 1'b1;
        nmi_n = 1'b0; #3; nmi_n = 1'b1;
        wait_entries(base + 1);
        chk(last_vec == 16'hFFFE, "R2", "glitch leaves vector", int'(last_vec), 16'hFFFE);
        run(40);
        chk(n_entries == base + 1, "R2", "glitch gives no entry", n_entries - base, 1);

        // R9: two edges close together, boundary every cycle
        ilen = 1; base = n_entries; nn = n_nmi;
        nmi_n = 1'b0; run(3); nmi_n = 1'b1; run(4); nmi_n = 1'b0; run(3); nmi_n = 1'b1;
        wait_entries(base + 2);
        chk(n_nmi == nn + 2, "R9", "close pair both serviced", n_nmi - nn, 2);
        run(20);

        // R1: random train of re-armed edges, random instruction lengths
        nn = n_nmi;
        for (int p = 0; p < 12; p++) begin
            ilen = $urandom_range(1, 3);
            nmi_n = 1'b0; run($urandom_range(2, 8));
            nmi_n = 1'b1; run($urandom_range(22, 30));
        end
        run(40);
        chk(n_nmi == nn + 12, "R1", "train entries", n_nmi - nn, 12);

        chk(!idle_bad, "R4", "strobes quiet outside entries", int'(idle_bad), 0);
        summary();
        $finish;
    end

endmodule